// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external host read and write a 4096-entry space of 16-bit registers over four wires: an active-low select, a serial clock, a data input and a data output. The serial inputs are synchronised into the block's faster system clock, and the rising edges of the serial clock are detected there. Every bit is taken on a rising serial clock edge. Every transaction opens with a 16-bit command word sent most significant bit first. Bit 15 is the direction (1 = read, 0 = write). Bits 14 and 13 are reserved. Bit 12 is the auto-increment flag. Bits 11 to 0 are the register address. Data words of 16 bits follow under the same select, also most significant bit first.

On the register side the block drives a simple synchronous port: an address, a single-cycle write strobe with write data, and a single-cycle read strobe. The read data must be valid in the system clock cycle that follows the read strobe. The read strobe is issued a few system clocks after the last command bit. For that reason a host must leave a longer gap before a read data word than before a write data word. With auto-increment set, any number of words may follow back to back, each at the next address. Without it, only the first word acts.

Top module: `srs_slave`

## Requirements
- R1: The command word is decoded as: bit 15 = direction (1 read, 0 write), bits 14..13 ignored, bit 12 = auto-increment, bits 11..0 = address. Every word is shifted most significant bit first on rising serial clock edges.
- R2: After the 16th bit of a write data word, exactly one single-cycle write strobe is issued, carrying the current address and the 16 bits received.
- R3: After the 16th command bit of a read, one read strobe is issued. The register data returned in the next system cycle appears on the data output with bit 15 before the first data edge. One further bit follows after each rising edge.
- R4: While the command word is shifting in, the data output carries the bit sampled on the most recent rising edge.
- R5: With auto-increment set, each further data word of the same transaction reads or writes the next consecutive address.
- R6: With auto-increment set, the address wraps from 4095 to 0.
- R7: With auto-increment clear, write words after the first cause no write strobe. Read words after the first shift out zeros.
- R8: Raising select at any point drops a partial word without a write strobe. The next transaction starts with a fresh command word.
- R9: Read and write strobes never coincide, and each lasts one system cycle.
- R10: During and after reset, the data output and both strobes are low.
- R11: Serial clock edges while select is high are ignored. While select is high, the data output stays low and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sclk | input | 1 | Serial clock from the host |
| host_csn | input | 1 | Active-low transaction select |
| host_sdi | input | 1 | Serial data from the host |
| host_sdo | output | 1 | Serial data to the host |
| rf_addr | output | 12 | Register address |
| rf_wr | output | 1 | Write strobe |
| rf_wdata | output | 16 | Write data |
| rf_rd | output | 1 | Read strobe |
| rf_rdata | input | 16 | Read data, valid the cycle after rf_rd |

## Verification
The assertions check the following on every cycle:
- the two strobes are exclusive, and each lasts a single cycle;
- every strobe lands exactly on a word boundary counted from select going low;
- consecutive strobes within one transaction step the address by one, with wrap;
- the output echoes each command bit;
- the output and strobes stay quiet while select is high.

Only the bench scenarios can show the data itself: values written into a modelled register file, read data shifted back out in order, and zeros after a non-incrementing first word. The same holds for an aborted partial word leaving a register untouched, and for reserved bits having no effect.

// File: rtl/srs_pkg.sv
package srs_pkg;

    localparam int ADDR_W  = 12;
    localparam int WORD_W  = 16;
    localparam int CNT_W   = $clog2(WORD_W);
    localparam int RD_POS  = WORD_W - 1;
    localparam int INC_POS = ADDR_W;

    // Decoded command: the reserved bits are not kept
    typedef struct packed {
        logic              rd;
        logic              inc;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef enum logic {
        PH_CMD,
        PH_DATA
    } phase_e;

    typedef enum logic [1:0] {
        TX_HOLD,
        TX_SHIFT,
        TX_LOAD,
        TX_CLEAR
    } tx_op_e;

    function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.rd   = w[RD_POS];
        c.inc  = w[INC_POS];
        c.addr = w[ADDR_W-1:0];
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                   input logic inc);
        return inc ? a + 1'b1 : a;
    endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/srs_edge.sv
module srs_edge (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign rise = en & lvl & ~prev_q;
endmodule

// File: rtl/srs_tx.sv
module srs_tx
    import srs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tx_op_e            op,
    input  logic [WORD_W-1:0] load_val,
    output logic              msb
);
    logic [WORD_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            case (op)
                TX_LOAD:  sr_q <= load_val;
                TX_SHIFT: sr_q <= {sr_q[WORD_W-2:0], 1'b0};
                TX_CLEAR: sr_q <= '0;
                default:  sr_q <= sr_q;
            endcase
        end
    end

    assign msb = sr_q[WORD_W-1];
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
    import srs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              bit_rise,
    input  logic              sdi_bit,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_rd,
    output tx_op_e            tx_op,
    output logic              tx_sel,
    output logic              echo_bit
);
    phase_e            phase_q;
    logic [CNT_W-1:0]  bit_q;
    logic [WORD_W-2:0] sr_q;
    logic              rd_q;
    logic              inc_q;
    logic              first_q;
    logic              rd_wait_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              echo_q;

    logic [WORD_W-1:0] sr_nxt;
    logic              word_done;
    cmd_t              cmd_nxt;

    assign sr_nxt    = {sr_q, sdi_bit};
    assign word_done = bit_rise && (bit_q == CNT_W'(WORD_W - 1));
    assign cmd_nxt   = decode_cmd(sr_nxt);

    // Output shift register control
    always_comb begin
        tx_op = TX_HOLD;
        if (!cs_act) begin
            tx_op = TX_CLEAR;
        end else if (rd_wait_q) begin
            tx_op = TX_LOAD;
        end else if (bit_rise && phase_q == PH_DATA && rd_q) begin
            tx_op = (word_done && !inc_q) ? TX_CLEAR : TX_SHIFT;
        end
    end

    assign tx_sel   = (phase_q == PH_DATA) && rd_q;
    assign echo_bit = echo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_CMD;
            bit_q     <= '0;
            sr_q      <= '0;
            rd_q      <= 1'b0;
            inc_q     <= 1'b0;
            first_q   <= 1'b0;
            rd_wait_q <= 1'b0;
            ptr_q     <= '0;
            echo_q    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
        end else if (!cs_act) begin
            phase_q   <= PH_CMD;
            bit_q     <= '0;
            sr_q      <= '0;
            first_q   <= 1'b0;
            rd_wait_q <= 1'b0;
            echo_q    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
        end else begin
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            rd_wait_q <= reg_rd;
            if (bit_rise) begin
                sr_q   <= sr_nxt[WORD_W-2:0];
                bit_q  <= bit_q + 1'b1;
                echo_q <= sdi_bit;
                if (word_done) begin
                    if (phase_q == PH_CMD) begin
                        phase_q <= PH_DATA;
                        rd_q    <= cmd_nxt.rd;
                        inc_q   <= cmd_nxt.inc;
                        first_q <= 1'b1;
                        if (cmd_nxt.rd) begin
                            reg_rd   <= 1'b1;
                            reg_addr <= cmd_nxt.addr;
                            ptr_q    <= step_addr(cmd_nxt.addr, cmd_nxt.inc);
                        end else begin
                            ptr_q <= cmd_nxt.addr;
                        end
                    end else begin
                        first_q <= 1'b0;
                        if (rd_q) begin
                            if (inc_q) begin
                                reg_rd   <= 1'b1;
                                reg_addr <= ptr_q;
                                ptr_q    <= ptr_q + 1'b1;
                            end
                        end else if (inc_q || first_q) begin
                            reg_wr    <= 1'b1;
                            reg_addr  <= ptr_q;
                            reg_wdata <= sr_nxt;
                            ptr_q     <= step_addr(ptr_q, inc_q);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/srs_slave.sv
module srs_slave
    import srs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sclk,
    input  logic              host_csn,
    input  logic              host_sdi,
    output logic              host_sdo,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_wr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic              rf_rd,
    input  logic [WORD_W-1:0] rf_rdata
);
    localparam int PIN_N = 3;

    logic [PIN_N-1:0] raw;
    logic [PIN_N-1:0] synced;
    logic             cs_act;
    logic             sclk_rise;
    tx_op_e           tx_op;
    logic             tx_sel;
    logic             tx_msb;
    logic             echo_bit;

    assign raw    = {host_csn, host_sclk, host_sdi};
    assign cs_act = ~synced[2];

    srs_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    srs_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .en   (cs_act),
        .lvl  (synced[1]),
        .rise (sclk_rise)
    );

    srs_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .bit_rise  (sclk_rise),
        .sdi_bit   (synced[0]),
        .reg_addr  (rf_addr),
        .reg_wr    (rf_wr),
        .reg_wdata (rf_wdata),
        .reg_rd    (rf_rd),
        .tx_op     (tx_op),
        .tx_sel    (tx_sel),
        .echo_bit  (echo_bit)
    );

    srs_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .op       (tx_op),
        .load_val (rf_rdata),
        .msb      (tx_msb)
    );

    assign host_sdo = tx_sel ? tx_msb : echo_bit;
endmodule

// File: rtl/srs_slave_chk.sv
module srs_slave_chk
    import srs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_act,
    input logic              sclk_rise,
    input logic              sdi_s,
    input logic              sdo,
    input logic              rf_wr,
    input logic              rf_rd,
    input logic [ADDR_W-1:0] rf_addr
);
    logic [15:0]       rise_cnt;
    logic              have_prev;
    logic [ADDR_W-1:0] last_addr;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            rise_cnt  <= '0;
            have_prev <= 1'b0;
            last_addr <= '0;
        end else begin
            if (sclk_rise) rise_cnt <= rise_cnt + 1'b1;
            if (rf_wr || rf_rd) begin
                have_prev <= 1'b1;
                last_addr <= rf_addr;
            end
        end
    end

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(rf_wr && rf_rd));

    assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rf_wr |=> !rf_wr);

    assert_wr_full_word_R8: assert property (@(posedge clk) disable iff (rst)
        rf_wr |-> (rise_cnt[3:0] == 4'd0 && rise_cnt >= 16'd32));

    assert_rd_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        rf_rd |-> (rise_cnt[3:0] == 4'd0 && rise_cnt >= 16'd16));

    // R6: the increment wraps inside the address width
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        ((rf_wr || rf_rd) && have_prev) |-> (rf_addr == last_addr + 1'b1));

    assert_cmd_echo_R4: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && rise_cnt < 16'd15) |=> (sdo == $past(sdi_s)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (!sdo && !rf_wr && !rf_rd));
endmodule

bind srs_slave srs_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sdi_s     (synced[0]),
    .sdo       (host_sdo),
    .rf_wr     (rf_wr),
    .rf_rd     (rf_rd),
    .rf_addr   (rf_addr)
);

// File: tb/srs_slave_bench.sv
module srs_slave_bench;
    localparam int HALF = 6;
    localparam int RGAP = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sclk = 1'b0;
    logic        host_csn = 1'b1;
    logic        host_sdi = 1'b0;
    logic        host_sdo;
    logic [11:0] rf_addr;
    logic        rf_wr;
    logic [15:0] rf_wdata;
    logic        rf_rd;
    logic [15:0] rf_rdata = '0;

    logic [15:0] mem [4096];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    logic        strobe_bad = 1'b0;
    logic        wr_prev = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    srs_slave u_srs_slave (
        .clk       (clk),
        .rst       (rst),
        .host_sclk (host_sclk),
        .host_csn  (host_csn),
        .host_sdi  (host_sdi),
        .host_sdo  (host_sdo),
        .rf_addr   (rf_addr),
        .rf_wr     (rf_wr),
        .rf_wdata  (rf_wdata),
        .rf_rd     (rf_rd),
        .rf_rdata  (rf_rdata)
    );

    // Register file model: read data valid the cycle after rf_rd
    always @(posedge clk) begin
        if (rf_wr) begin
            mem[rf_addr] <= rf_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (rf_rd) begin
            rf_rdata <= mem[rf_addr];
            rd_cnt <= rd_cnt + 1;
        end
        if (!rst && ((rf_wr && rf_rd) || (rf_wr && wr_prev))) strobe_bad <= 1'b1;
        wr_prev <= rf_wr;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic cs_start();
        @(negedge clk) host_csn = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_stop();
        repeat (6) @(negedge clk);
        host_csn = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
        rx = '0;
        for (int i = 15; i > 15 - nbits; i--) begin
            host_sdi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = host_sdo;
            host_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            host_sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [15:0] tx, output logic [15:0] rx);
        xfer_bits(tx, 16, rx);
    endtask

    task automatic wr1(input logic [11:0] a, input logic [15:0] d);
        logic [15:0] rx;
        cs_start();
        xfer({4'b0000, a}, rx);
        gap(8);
        xfer(d, rx);
        cs_stop();
    endtask

    // {rd, rsv[1:0], addr[11:0], data[15:0]}; reads expect the data field
    localparam logic [30:0] VEC [8] = '{
        {1'b0, 2'b00, 12'h000, 16'hA5C3},
        {1'b0, 2'b11, 12'hFFF, 16'h3C5A},
        {1'b0, 2'b10, 12'h123, 16'hFFFF},
        {1'b0, 2'b01, 12'h800, 16'h0001},
        {1'b1, 2'b00, 12'h000, 16'hA5C3},
        {1'b1, 2'b11, 12'hFFF, 16'h3C5A},
        {1'b1, 2'b01, 12'h123, 16'hFFFF},
        {1'b1, 2'b10, 12'h800, 16'h0001}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            report();
        end
    end

    initial begin
        logic [15:0] cmd, rx, rd;
        int w0;

        // R10: outputs held low during reset
        repeat (5) @(negedge clk);
        chk(host_sdo == 1'b0 && rf_wr == 1'b0 && rf_rd == 1'b0, "R10 reset",
            {host_sdo, rf_wr, rf_rd}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(host_sdo == 1'b0 && rf_wr == 1'b0 && rf_rd == 1'b0, "R10 after reset",
            {host_sdo, rf_wr, rf_rd}, 0);

        // Table walk: R1 (reserved bits vary), R2, R3, R4
        for (int v = 0; v < 8; v++) begin
            cmd = {VEC[v][30], VEC[v][29:28], 1'b0, VEC[v][27:16]};
            w0 = wr_cnt;
            cs_start();
            xfer(cmd, rx);
            chk(rx[14:0] == cmd[15:1], "R4 echo", rx[14:0], cmd[15:1]);
            if (VEC[v][30]) begin
                gap(RGAP);
                xfer(16'h0000, rd);
                chk(rd == VEC[v][15:0], "R3 R1 read", rd, VEC[v][15:0]);
                cs_stop();
            end else begin
                gap(8);
                xfer(VEC[v][15:0], rx);
                cs_stop();
                chk(mem[VEC[v][27:16]] == VEC[v][15:0], "R2 R1 write",
                    mem[VEC[v][27:16]], VEC[v][15:0]);
                chk(wr_cnt == w0 + 1, "R2 one strobe", wr_cnt, w0 + 1);
            end
        end

        // R5 R6: incrementing write burst across the top of the space
        w0 = wr_cnt;
        cs_start();
        xfer({4'b0001, 12'hFFE}, rx);
        gap(8); xfer(16'h1111, rx);
        gap(8); xfer(16'h2222, rx);
        gap(8); xfer(16'h3333, rx);
        cs_stop();
        chk(mem[12'hFFE] == 16'h1111, "R5 burst word0", mem[12'hFFE], 16'h1111);
        chk(mem[12'hFFF] == 16'h2222, "R5 burst word1", mem[12'hFFF], 16'h2222);
        chk(mem[12'h000] == 16'h3333, "R6 wrap write", mem[12'h000], 16'h3333);
        chk(wr_cnt == w0 + 3, "R5 strobe count", wr_cnt, w0 + 3);

        // R5 R6: incrementing read burst across the wrap
        cs_start();
        xfer({4'b1001, 12'hFFF}, rx);
        gap(RGAP); xfer(16'h0000, rd);
        chk(rd == 16'h2222, "R5 burst read0", rd, 16'h2222);
        gap(RGAP); xfer(16'h0000, rd);
        chk(rd == 16'h3333, "R6 wrap read", rd, 16'h3333);
        cs_stop();

        // R7: non-incrementing write, second word ignored
        wr1(12'h011, 16'h0BAD);
        w0 = wr_cnt;
        cs_start();
        xfer({4'b0000, 12'h010}, rx);
        gap(8); xfer(16'h4444, rx);
        gap(8); xfer(16'h5555, rx);
        cs_stop();
        chk(mem[12'h010] == 16'h4444, "R7 first write", mem[12'h010], 16'h4444);
        chk(mem[12'h011] == 16'h0BAD, "R7 neighbour untouched", mem[12'h011], 16'h0BAD);
        chk(wr_cnt == w0 + 1, "R7 single strobe", wr_cnt, w0 + 1);

        // R7: non-incrementing read, second word zeros
        w0 = rd_cnt;
        cs_start();
        xfer({4'b1000, 12'h010}, rx);
        gap(RGAP); xfer(16'h0000, rd);
        chk(rd == 16'h4444, "R7 first read", rd, 16'h4444);
        gap(RGAP); xfer(16'h0000, rd);
        chk(rd == 16'h0000, "R7 zero word", rd, 16'h0000);
        cs_stop();
        chk(rd_cnt == w0 + 1, "R7 single read strobe", rd_cnt, w0 + 1);

        // R8: abort in mid-word
        wr1(12'h020, 16'h7777);
        w0 = wr_cnt;
        cs_start();
        xfer({4'b0000, 12'h020}, rx);
        gap(8); xfer_bits(16'h9999, 8, rx);
        cs_stop();
        chk(wr_cnt == w0, "R8 no strobe on abort", wr_cnt, w0);
        chk(mem[12'h020] == 16'h7777, "R8 register kept", mem[12'h020], 16'h7777);
        wr1(12'h020, 16'h8888);
        chk(mem[12'h020] == 16'h8888, "R8 fresh transaction", mem[12'h020], 16'h8888);

        // R11: clock edges with select high
        w0 = wr_cnt + rd_cnt;
        host_sdi = 1'b1;
        for (int k = 0; k < 6; k++) begin
            repeat (HALF) @(negedge clk); host_sclk = 1'b1;
            repeat (HALF) @(negedge clk); host_sclk = 1'b0;
            chk(host_sdo == 1'b0, "R11 sdo idle", host_sdo, 0);
        end
        gap(6);
        chk(wr_cnt + rd_cnt == w0, "R11 no strobe", wr_cnt + rd_cnt, w0);
        wr1(12'h0AB, 16'hC0DE);
        chk(mem[12'h0AB] == 16'hC0DE, "R11 counter undisturbed", mem[12'h0AB], 16'hC0DE);

        // R9: strobe monitor over the whole run
        chk(strobe_bad == 1'b0, "R9 strobe shape", strobe_bad, 0);

        done = 1'b1;
        report();
    end
endmodule